// File: doc/BRIEF.md
# Video Memory Address Translator

This block sits between a raster controller and screen memory. Each cycle it may take one request made of a 14-bit character address, a 3-bit raster line, a teletext flag and a 2-bit wrap select. It returns the 15-bit byte address in screen RAM that the request names. In bitmap modes every character address covers eight consecutive bytes, one per raster line. A byte address that runs past the top of RAM is folded back down by an amount chosen by the wrap select, so a screen can scroll continuously through a buffer ending at 0x7FFF. In teletext mode a different mapping places each address in one of two 1 KiB windows.

Requests arrive on a valid/ready input and leave on a valid/ready output through a single register stage. An input is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its contents are being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its address unchanged and no new request is taken.

Top module: `video_addr_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, `out_addr` is 0 and `in_ready` is 1.
- R2: In bitmap mode (`in_ttx`=0), when in_ma×8+in_ra is below 0x8000, the output address equals in_ma×8+in_ra.
- R3: In bitmap mode, when in_ma×8+in_ra is 0x8000 or more, a wrap amount is subtracted and the low 15 bits are kept. `in_wrap_sel` picks the amount: 0 gives 0x4000, 1 gives 0x2000, 2 gives 0x5000 and 3 gives 0x2800.
- R4: In teletext mode (`in_ttx`=1), the output is ((in_ma & 0x800) << 3) | 0x3C00 | (in_ma & 0x3FF). It therefore lies in 0x3C00–0x3FFF when in_ma bit 11 is 0, and in 0x7C00–0x7FFF when it is 1.
- R5: In teletext mode, `in_ra`, `in_wrap_sel` and in_ma bits 13, 12 and 10 have no effect on the output.
- R6: A request accepted at one clock edge appears on `out_addr` with `out_valid` high after that same edge, which gives one cycle of latency.
- R7: While `out_valid`=1 and `out_ready`=0, `out_addr` and `out_valid` hold, and `in_ready` is 0, so an offered input is not taken.
- R8: When the output is taken and no new request is accepted, `out_valid` falls at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request this cycle |
| in_ma | input | 14 | Character memory address |
| in_ra | input | 3 | Raster line within the character |
| in_ttx | input | 1 | 1 selects the teletext mapping |
| in_wrap_sel | input | 2 | Wrap amount select for bitmap modes |
| out_valid | output | 1 | `out_addr` holds a result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_addr | output | 15 | Physical screen RAM byte address |

## Verification
The bench sweeps every character address in both modes, varying the raster line and wrap select along the way, and compares each result with an arithmetic model. This catches a swapped select encoding or a wrong subtraction amount, since a wrong amount puts wrapped rows in the wrong place. It also catches a compare at 0x7FFF instead of 0x8000, which would leave the top byte wrapped or unwrapped wrongly. Directed cases land on both sides of the 0x8000 edge for every select value and at the largest address, where missing truncation would show. Back-pressure is held for several cycles with a different request offered, to expose a register that overwrites its held result or a valid flag that does not fall once the result is taken.

// File: rtl/vat_pkg.sv
package vat_pkg;
  localparam int WRAP_AMT_W = 16;

  function automatic logic [WRAP_AMT_W-1:0] wrap_amount(input logic [1:0] sel);
    logic [WRAP_AMT_W-1:0] amt;
    case (sel)
      2'd0:    amt = 16'h4000;
      2'd1:    amt = 16'h2000;
      2'd2:    amt = 16'h5000;
      default: amt = 16'h2800;
    endcase
    return amt;
  endfunction
endpackage

// File: rtl/vat_bitmap_map.sv
module vat_bitmap_map #(
  parameter int MA_W   = 14,
  parameter int RA_W   = 3,
  parameter int ADDR_W = 15
) (
  input  logic [MA_W-1:0]   ma,
  input  logic [RA_W-1:0]   ra,
  input  logic [1:0]        wrap_sel,
  output logic [ADDR_W-1:0] addr
);
  import vat_pkg::*;

  localparam int BYTE_W = MA_W + RA_W;
  localparam logic [BYTE_W-1:0] RAM_TOP = BYTE_W'(1) << ADDR_W;

  logic [BYTE_W-1:0] byte_addr;
  logic [BYTE_W-1:0] folded;
  logic              past_top;

  always_comb begin
    byte_addr = {ma, ra};
    past_top  = (byte_addr >= RAM_TOP);
    folded    = past_top ? (byte_addr - BYTE_W'(wrap_amount(wrap_sel))) : byte_addr;
    addr      = folded[ADDR_W-1:0];
  end
endmodule

// File: rtl/vat_ttx_map.sv
module vat_ttx_map #(
  parameter int MA_W   = 14,
  parameter int ADDR_W = 15
) (
  input  logic [MA_W-1:0]   ma,
  output logic [ADDR_W-1:0] addr
);
  localparam int WIN_BITS = 10;
  localparam logic [3:0] WIN_BASE = 4'hF;

  logic [WIN_BITS+4:0] mapped;

  always_comb begin
    mapped = {ma[11], WIN_BASE, ma[WIN_BITS-1:0]};
    addr   = ADDR_W'(mapped);
  end
endmodule

// File: rtl/vat_out_reg.sv
module vat_out_reg #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/video_addr_xlate.sv
module video_addr_xlate #(
  parameter int MA_W   = 14,
  parameter int RA_W   = 3,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MA_W-1:0]   in_ma,
  input  logic [RA_W-1:0]   in_ra,
  input  logic              in_ttx,
  input  logic [1:0]        in_wrap_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] bmp_addr;
  logic [ADDR_W-1:0] ttx_addr;
  logic [ADDR_W-1:0] next_addr;

  vat_bitmap_map #(.MA_W(MA_W), .RA_W(RA_W), .ADDR_W(ADDR_W)) u_bitmap (
    .ma(in_ma), .ra(in_ra), .wrap_sel(in_wrap_sel), .addr(bmp_addr)
  );

  vat_ttx_map #(.MA_W(MA_W), .ADDR_W(ADDR_W)) u_ttx (
    .ma(in_ma), .addr(ttx_addr)
  );

  assign next_addr = in_ttx ? ttx_addr : bmp_addr;

  vat_out_reg #(.WIDTH(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(next_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_addr)
  );

  assert_ttx_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ttx) |=>
      (out_addr[13:10] == 4'hF && out_addr[14] == $past(in_ma[11])));

  assert_plain_bitmap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_ttx && in_ma[MA_W-1:MA_W-2] == 2'b00 && !in_ma[MA_W-3]) |=>
      (out_addr == $past({in_ma[MA_W-4:0], in_ra})));
endmodule

// File: tb/test_video_addr_xlate.sv
module test_video_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_ma = '0;
  logic [2:0]  in_ra = '0;
  logic        in_ttx = 1'b0;
  logic [1:0]  in_wrap_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [14:0] out_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  video_addr_xlate i_video_addr_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ma(in_ma), .in_ra(in_ra), .in_ttx(in_ttx), .in_wrap_sel(in_wrap_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic int model(input int ma, input int ra, input bit ttx, input int sel);
    int b;
    int amt[4] = '{32'h4000, 32'h2000, 32'h5000, 32'h2800};
    if (ttx) return ((ma & 32'h800) << 3) | 32'h3C00 | (ma & 32'h3FF);
    b = ma * 8 + ra;
    if (b >= 32'h8000) b = b - amt[sel];
    return b & 32'h7FFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int ma, input int ra, input bit ttx, input int sel, input string req);
    int exp;
    exp = model(ma, ra, ttx, sel);
    @(negedge clk);
    in_ma = 14'(ma); in_ra = 3'(ra); in_ttx = ttx; in_wrap_sel = 2'(sel);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && int'(out_addr) == exp, req, int'(out_addr), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);
    check(out_addr == 15'd0, "R1 out_addr", int'(out_addr), 0);

    // R2/R3/R6: bitmap sweep over every character address
    for (int i = 0; i < 16384; i++) begin
      if (i * 8 + ((i * 5) & 7) < 32'h8000)
        send(i, (i * 5) & 7, 1'b0, (i >> 2) & 3, "R2 bitmap");
      else
        send(i, (i * 5) & 7, 1'b0, (i >> 2) & 3, "R3 wrap");
    end

    // R4/R5: teletext sweep with raster line and select varied
    for (int i = 0; i < 16384; i++)
      send(i, (i * 3) & 7, 1'b1, (i >> 1) & 3, "R4 R5 teletext");

    // R5: same address, changed ignored inputs
    for (int k = 0; k < 8; k++)
      send(32'h0A55 | ((k & 3) << 12) | ((k >> 2) << 10), k, 1'b1, k & 3, "R5 ignored bits");

    // R3: both sides of the 0x8000 edge for every select, and the top address
    for (int s = 0; s < 4; s++) begin
      send(32'h0FFF, 7, 1'b0, s, "R3 below edge");
      send(32'h1000, 0, 1'b0, s, "R3 at edge");
      send(32'h3FFF, 7, 1'b0, s, "R3 top address");
    end

    // R7: back-pressure hold
    @(negedge clk);
    in_ma = 14'h0123; in_ra = 3'd4; in_ttx = 1'b0; in_wrap_sel = 2'd0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_ma = 14'h0456; in_ra = 3'd1;
    for (int c = 0; c < 4; c++) begin
      check(out_valid, "R7 valid held", int'(out_valid), 1);
      check(!in_ready, "R7 in_ready low", int'(in_ready), 0);
      check(int'(out_addr) == 32'h091C, "R7 data held", int'(out_addr), 32'h091C);
      @(negedge clk);
    end
    // R8: take the result with nothing offered
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R8 valid falls", int'(out_valid), 0);
    check(int'(out_addr) == 32'h091C, "R7 refused input not stored", int'(out_addr), 32'h091C);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule